// File: doc/BRIEF.md
# Short I/O Write-Register Bus Slave

This block is the bus-facing front end of a four-channel output card on an asynchronous 16-bit-address backplane bus. It watches every cycle on the bus, claims those that fall inside its own 1K-byte window of the short I/O space, and answers them with a data-transfer acknowledge. The window base is set by a 6-bit strap that is compared with address bits 15:10. A second strap picks the privilege policy. With the strap set, only supervisory short-I/O accesses (address-modifier code 0x2D) are claimed. With it cleared, non-privileged ones (0x29) are claimed as well.

Inside the window, four 16-bit write-only channel registers sit at word offsets 0x88, 0x8A, 0x8C and 0x8E, for channels 0 to 3. For each accepted write that lands on one of them, the block issues a single-cycle one-hot channel strobe. The strobe comes with two byte-lane enables and the captured data word, so that the register file behind it can update the high byte, the low byte or both. Reads and writes to other offsets in the window are acknowledged, but they change nothing. A cycle with the long-word line active, a refused modifier code or a foreign base is left alone for another slave to answer.

The bus inputs are taken to be synchronous to `clk`. An acknowledge appears one clock after the block first sees address strobe and a data strobe low together. It then stays asserted until both data strobes are high again.

Top module: `short_io_slave`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `dtack_n` is 1, `ch_sel` is all zero and both lane enables are 0.
- R2: With `priv_strap`=1 only `am`=0x2D is claimed. With `priv_strap`=0 both 0x2D and 0x29 are claimed. Any other code gets no acknowledge and no strobe.
- R3: A cycle is claimed only when address bits 15:10 equal `base_strap`. Any other base gets no acknowledge and no strobe.
- R4: A claimed write at byte offset (address bits 9:0) 0x88+2·k, for k in 0..3, pulses only `ch_sel` bit k. Bit 0 of `ch_sel` is channel 0.
- R5: `ds1_n` low selects the high byte (D15:8, even byte address) and drives `lane_hi`=1. `ds0_n` low selects the low byte (D7:0, odd byte address) and drives `lane_lo`=1. A word write sets both lanes in the same strobe cycle.
- R6: `dtack_n` falls in the cycle after the clock edge that first samples `as_n`=0, at least one data strobe low, and a claimed address. Any write strobe is high for exactly that one cycle.
- R7: Claimed writes to window offsets outside 0x88..0x8F are acknowledged but pulse no channel strobe.
- R8: With `lword_n`=0 no cycle is claimed: no acknowledge and no strobe.
- R9: A claimed read (`write_n`=1) is acknowledged and pulses no channel strobe.
- R10: `dtack_n` stays 0 while either data strobe is low. It returns to 1 in the cycle after the edge that samples both data strobes high.
- R11: During a strobe cycle `wr_data` equals the value `data_in` had at the edge where the cycle was accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all bus inputs are synchronous to it |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 15 | Bus address bits 15:1 |
| am | input | 6 | Address-modifier code |
| as_n | input | 1 | Address strobe, active low |
| ds0_n | input | 1 | Low-byte data strobe, active low |
| ds1_n | input | 1 | High-byte data strobe, active low |
| write_n | input | 1 | 0 for a write cycle, 1 for a read |
| lword_n | input | 1 | Long-word transfer indicator, active low |
| data_in | input | 16 | Bus data lines D15:0 |
| base_strap | input | 6 | Window base, compared with address bits 15:10 |
| priv_strap | input | 1 | 1 claims supervisory accesses only |
| dtack_n | output | 1 | Data-transfer acknowledge, active low |
| ch_sel | output | 4 | One-hot channel write strobe, one cycle |
| lane_hi | output | 1 | High-byte enable, valid with `ch_sel` |
| lane_lo | output | 1 | Low-byte enable, valid with `ch_sel` |
| wr_data | output | 16 | Write data, valid with `ch_sel` |

## Verification
The channel strobe and the leading edge of the acknowledge come from the same accepting clock edge, so both change in one cycle. Every cycle the bench compares both against its behavioural model, and an early, late or doubled pulse shows up as a mismatch. The release of the acknowledge and the acceptance of a fresh cycle can also meet. To provoke this, back-to-back cycles leave only the minimum idle time between them, and a held cycle keeps its data strobes low for many clocks. The model then judges that the acknowledge drops exactly one cycle after both strobes are seen high, and that the held cycle produces one strobe only.

// File: rtl/sio_pkg.sv
package sio_pkg;

    typedef enum logic [0:0] {
        HS_IDLE = 1'b0,
        HS_ACK  = 1'b1
    } hs_state_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } lanes_t;

    // Privilege policy: the supervisory code is always taken; the user
    // code only when the strap does not restrict access.
    function automatic logic am_accept(
        input logic [5:0] code,
        input logic       sup_only,
        input logic [5:0] sup_code,
        input logic [5:0] usr_code
    );
        return (code == sup_code) || (!sup_only && (code == usr_code));
    endfunction

endpackage

// File: rtl/sio_match.sv
module sio_match #(
    parameter int          BASE_W = 6,
    parameter logic [5:0]  AM_SUP = 6'h2D,
    parameter logic [5:0]  AM_USR = 6'h29
) (
    input  logic [BASE_W-1:0] addr_hi,
    input  logic [BASE_W-1:0] base_strap,
    input  logic [5:0]        am,
    input  logic              priv_strap,
    input  logic              lword_n,
    output logic              hit
);
    import sio_pkg::*;

    logic base_ok;
    logic code_ok;

    always_comb begin
        base_ok = (addr_hi == base_strap);
        code_ok = am_accept(am, priv_strap, AM_SUP, AM_USR);
        hit     = base_ok && code_ok && lword_n;
    end

endmodule

// File: rtl/sio_reg_decode.sv
module sio_reg_decode #(
    parameter int WIN_W   = 10,
    parameter int NUM_CH  = 4,
    parameter int REG_OFF = 'h88
) (
    input  logic [WIN_W-2:0]  word_off,
    output logic [NUM_CH-1:0] ch_hit,
    output logic              reg_hit
);
    localparam int OW       = WIN_W - 1;
    localparam int FIRST_WD = REG_OFF / 2;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int WORD_IDX = FIRST_WD + i;
        assign ch_hit[i] = (word_off == OW'(WORD_IDX));
    end

    assign reg_hit = |ch_hit;

endmodule

// File: rtl/sio_handshake.sv
module sio_handshake #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_n,
    input  logic              ds0_n,
    input  logic              ds1_n,
    input  logic              write_n,
    input  logic              hit,
    input  logic              reg_hit,
    input  logic [NUM_CH-1:0] ch_hit,
    input  logic [DATA_W-1:0] data_in,
    output logic              dtack_n,
    output logic [NUM_CH-1:0] ch_sel,
    output logic              lane_hi,
    output logic              lane_lo,
    output logic [DATA_W-1:0] wr_data
);
    import sio_pkg::*;

    typedef struct packed {
        hs_state_e         state;
        logic [NUM_CH-1:0] ch;
        lanes_t            lanes;
        logic [DATA_W-1:0] data;
    } hs_t;

    hs_t hs_d;
    hs_t hs_q;

    logic any_ds;
    logic no_ds;

    always_comb begin
        any_ds         = !ds0_n || !ds1_n;
        no_ds          = ds0_n && ds1_n;
        hs_d           = hs_q;
        hs_d.ch        = '0;
        hs_d.lanes     = '0;
        case (hs_q.state)
            HS_IDLE: begin
                if (!as_n && any_ds && hit) begin
                    hs_d.state = HS_ACK;
                    if (!write_n && reg_hit) begin
                        hs_d.ch       = ch_hit;
                        hs_d.lanes.hi = !ds1_n;
                        hs_d.lanes.lo = !ds0_n;
                        hs_d.data     = data_in;
                    end
                end
            end
            HS_ACK: begin
                if (no_ds) begin
                    hs_d.state = HS_IDLE;
                end
            end
            default: hs_d.state = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= '{state: HS_IDLE, ch: '0, lanes: '0, data: '0};
        end else begin
            hs_q <= hs_d;
        end
    end

    assign dtack_n = (hs_q.state != HS_ACK);
    assign ch_sel  = hs_q.ch;
    assign lane_hi = hs_q.lanes.hi;
    assign lane_lo = hs_q.lanes.lo;
    assign wr_data = hs_q.data;

endmodule

// File: rtl/short_io_slave.sv
module short_io_slave #(
    parameter int         ADDR_W  = 16,
    parameter int         WIN_W   = 10,
    parameter int         NUM_CH  = 4,
    parameter int         DATA_W  = 16,
    parameter int         REG_OFF = 'h88,
    parameter logic [5:0] AM_SUP  = 6'h2D,
    parameter logic [5:0] AM_USR  = 6'h29
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:1]       addr,
    input  logic [5:0]              am,
    input  logic                    as_n,
    input  logic                    ds0_n,
    input  logic                    ds1_n,
    input  logic                    write_n,
    input  logic                    lword_n,
    input  logic [DATA_W-1:0]       data_in,
    input  logic [ADDR_W-WIN_W-1:0] base_strap,
    input  logic                    priv_strap,
    output logic                    dtack_n,
    output logic [NUM_CH-1:0]       ch_sel,
    output logic                    lane_hi,
    output logic                    lane_lo,
    output logic [DATA_W-1:0]       wr_data
);
    localparam int BASE_W = ADDR_W - WIN_W;

    logic              hit;
    logic              reg_hit;
    logic [NUM_CH-1:0] ch_hit;

    sio_match #(
        .BASE_W (BASE_W),
        .AM_SUP (AM_SUP),
        .AM_USR (AM_USR)
    ) u_match (
        .addr_hi    (addr[ADDR_W-1:WIN_W]),
        .base_strap (base_strap),
        .am         (am),
        .priv_strap (priv_strap),
        .lword_n    (lword_n),
        .hit        (hit)
    );

    sio_reg_decode #(
        .WIN_W   (WIN_W),
        .NUM_CH  (NUM_CH),
        .REG_OFF (REG_OFF)
    ) u_dec (
        .word_off (addr[WIN_W-1:1]),
        .ch_hit   (ch_hit),
        .reg_hit  (reg_hit)
    );

    sio_handshake #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W)
    ) u_hs (
        .clk     (clk),
        .rst_n   (rst_n),
        .as_n    (as_n),
        .ds0_n   (ds0_n),
        .ds1_n   (ds1_n),
        .write_n (write_n),
        .hit     (hit),
        .reg_hit (reg_hit),
        .ch_hit  (ch_hit),
        .data_in (data_in),
        .dtack_n (dtack_n),
        .ch_sel  (ch_sel),
        .lane_hi (lane_hi),
        .lane_lo (lane_lo),
        .wr_data (wr_data)
    );

endmodule

// File: rtl/sio_checker.sv
module sio_checker #(
    parameter int         NUM_CH = 4,
    parameter logic [5:0] AM_SUP = 6'h2D
) (
    input logic              clk,
    input logic              rst_n,
    input logic              as_n,
    input logic              ds0_n,
    input logic              ds1_n,
    input logic              write_n,
    input logic              lword_n,
    input logic [5:0]        am,
    input logic              priv_strap,
    input logic              dtack_n,
    input logic [NUM_CH-1:0] ch_sel,
    input logic              lane_hi,
    input logic              lane_lo
);

    // R6
    ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtack_n) |-> $past(!as_n && !(ds0_n && ds1_n)));

    // R2
    priv_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dtack_n) && $past(priv_strap)) |-> ($past(am) == AM_SUP));

    // R8
    lword_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtack_n) |-> $past(lword_n));

    // R4
    onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_sel));

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_sel) |=> (ch_sel == '0));

    // R6
    strobe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_sel) |-> $fell(dtack_n));

    // R9
    write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_sel) |-> $past(!write_n));

    // R5
    lane_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_sel) |-> ((lane_hi == $past(!ds1_n)) && (lane_lo == $past(!ds0_n))));

    // R10
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && !(ds0_n && ds1_n)) |=> !dtack_n);

    // R10
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && ds0_n && ds1_n) |=> dtack_n);

endmodule

bind short_io_slave sio_checker #(
    .NUM_CH (NUM_CH),
    .AM_SUP (AM_SUP)
) u_sio_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .as_n       (as_n),
    .ds0_n      (ds0_n),
    .ds1_n      (ds1_n),
    .write_n    (write_n),
    .lword_n    (lword_n),
    .am         (am),
    .priv_strap (priv_strap),
    .dtack_n    (dtack_n),
    .ch_sel     (ch_sel),
    .lane_hi    (lane_hi),
    .lane_lo    (lane_lo)
);

// File: tb/tb_short_io_slave.sv
module tb_short_io_slave;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr_full = 16'h0;
    logic [5:0]  am = 6'h0;
    logic        as_n = 1'b1;
    logic        ds0_n = 1'b1;
    logic        ds1_n = 1'b1;
    logic        write_n = 1'b1;
    logic        lword_n = 1'b1;
    logic [15:0] data_in = 16'h0;
    logic [5:0]  base_strap = 6'h04;
    logic        priv_strap = 1'b0;
    logic        dtack_n;
    logic [3:0]  ch_sel;
    logic        lane_hi;
    logic        lane_lo;
    logic [15:0] wr_data;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    comparing = 1'b0;

    // behavioural reference state
    bit          m_ack;
    int          m_ch;
    bit          m_hi;
    bit          m_lo;
    logic [15:0] m_data;

    always #2 clk = ~clk;

    short_io_slave dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr_full[15:1]),
        .am         (am),
        .as_n       (as_n),
        .ds0_n      (ds0_n),
        .ds1_n      (ds1_n),
        .write_n    (write_n),
        .lword_n    (lword_n),
        .data_in    (data_in),
        .base_strap (base_strap),
        .priv_strap (priv_strap),
        .dtack_n    (dtack_n),
        .ch_sel     (ch_sel),
        .lane_hi    (lane_hi),
        .lane_lo    (lane_lo),
        .wr_data    (wr_data)
    );

    function automatic bit claims();
        int base_idx;
        bit code_ok;
        base_idx = int'(addr_full) / 1024;
        code_ok  = (am == 6'h2D) || (priv_strap == 1'b0 && am == 6'h29);
        return (base_idx == int'(base_strap)) && code_ok && (lword_n == 1'b1);
    endfunction

    always @(posedge clk) begin
        int off;
        if (!rst_n) begin
            m_ack <= 1'b0;
            m_ch  <= -1;
            m_hi  <= 1'b0;
            m_lo  <= 1'b0;
        end else begin
            m_ch <= -1;
            m_hi <= 1'b0;
            m_lo <= 1'b0;
            if (!m_ack) begin
                if (!as_n && (!ds0_n || !ds1_n) && claims()) begin
                    m_ack <= 1'b1;
                    off = int'(addr_full) % 1024;
                    if (!write_n && off >= 'h88 && off <= 'h8F) begin
                        m_ch   <= (off - 'h88) / 2;
                        m_hi   <= !ds1_n;
                        m_lo   <= !ds0_n;
                        m_data <= data_in;
                    end
                end
            end else if (ds0_n && ds1_n) begin
                m_ack <= 1'b0;
            end
        end
    end

    always @(negedge clk) begin
        logic [3:0] exp_sel;
        bit bad;
        if (comparing) begin
            exp_sel = (m_ch < 0) ? 4'b0000 : 4'(1 << m_ch);
            bad = (dtack_n !== !m_ack) || (ch_sel !== exp_sel) ||
                  (lane_hi !== m_hi) || (lane_lo !== m_lo) ||
                  (m_ch >= 0 && wr_data !== m_data);
            checks++;
            if (bad) begin
                errors++;
                $display("FAIL %s t=%0t got dtack_n=%b sel=%b hi=%b lo=%b data=%h expected dtack_n=%b sel=%b hi=%b lo=%b data=%h",
                         cur_req, $time, dtack_n, ch_sel, lane_hi, lane_lo, wr_data,
                         !m_ack, exp_sel, m_hi, m_lo, m_data);
            end
        end
    end

    task automatic bus_cycle(input logic [15:0] a, input logic [5:0] code,
                             input bit wr, input bit hi, input bit lo,
                             input bit lw_n, input logic [15:0] d, input int hold);
        @(negedge clk); #1;
        addr_full = a; am = code; write_n = !wr; lword_n = lw_n; data_in = d;
        as_n = 1'b0;
        @(negedge clk); #1;
        ds1_n = !hi; ds0_n = !lo;
        repeat (hold) @(negedge clk);
        #1;
        ds0_n = 1'b1; ds1_n = 1'b1;
        @(negedge clk); #1;
        as_n = 1'b1; lword_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired in %s", cur_req);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state, during and just after reset
        repeat (3) @(negedge clk);
        checks++;
        if (dtack_n !== 1'b1 || ch_sel !== 4'b0 || lane_hi !== 1'b0 || lane_lo !== 1'b0) begin
            errors++;
            $display("FAIL R1 in reset got dtack_n=%b sel=%b hi=%b lo=%b expected 1 0000 0 0",
                     dtack_n, ch_sel, lane_hi, lane_lo);
        end
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (dtack_n !== 1'b1 || ch_sel !== 4'b0) begin
            errors++;
            $display("FAIL R1 after reset got dtack_n=%b sel=%b expected 1 0000", dtack_n, ch_sel);
        end
        comparing = 1'b1;

        // R4 R11: word writes to each channel, user code allowed
        cur_req = "R4/R11 word write per channel";
        for (int k = 0; k < 4; k++)
            bus_cycle(16'h1088 + 16'(2 * k), 6'h29, 1'b1, 1'b1, 1'b1, 1'b1,
                      16'hA5C0 + 16'(k), 1);
        idle(2);

        // R5: byte lanes, even byte on high lane, odd byte on low lane
        cur_req = "R5 low byte then high byte";
        bus_cycle(16'h108B, 6'h2D, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0034, 1);
        bus_cycle(16'h108A, 6'h2D, 1'b1, 1'b1, 1'b0, 1'b1, 16'h1200, 1);
        cur_req = "R5 word write both lanes";
        bus_cycle(16'h108E, 6'h2D, 1'b1, 1'b1, 1'b1, 1'b1, 16'hFFFF, 2);

        // R2: privilege strap
        cur_req = "R2 user code refused with strap set";
        priv_strap = 1'b1;
        bus_cycle(16'h1088, 6'h29, 1'b1, 1'b1, 1'b1, 1'b1, 16'h1111, 2);
        cur_req = "R2 supervisory code accepted with strap set";
        bus_cycle(16'h108C, 6'h2D, 1'b1, 1'b1, 1'b1, 1'b1, 16'h2222, 1);
        cur_req = "R2 foreign code refused";
        priv_strap = 1'b0;
        bus_cycle(16'h108C, 6'h3D, 1'b1, 1'b1, 1'b1, 1'b1, 16'h3333, 1);

        // R3: base matching
        cur_req = "R3 neighbouring block ignored";
        bus_cycle(16'h1488, 6'h2D, 1'b1, 1'b1, 1'b1, 1'b1, 16'h4444, 1);
        bus_cycle(16'h0C88, 6'h2D, 1'b1, 1'b1, 1'b1, 1'b1, 16'h4545, 1);
        cur_req = "R3 top block base";
        idle(1);
        base_strap = 6'h3F;
        bus_cycle(16'hFC8A, 6'h2D, 1'b1, 1'b1, 1'b1, 1'b1, 16'h5A5A, 1);
        base_strap = 6'h00;
        cur_req = "R3 bottom block base";
        bus_cycle(16'h0088, 6'h29, 1'b1, 1'b1, 1'b1, 1'b1, 16'h6B6B, 1);
        base_strap = 6'h04;

        // R8: long-word transfer left alone
        cur_req = "R8 lword active";
        bus_cycle(16'h1088, 6'h2D, 1'b1, 1'b1, 1'b1, 1'b0, 16'h7777, 2);

        // R7: undefined offsets in the window
        cur_req = "R7 undefined offsets";
        bus_cycle(16'h1086, 6'h2D, 1'b1, 1'b1, 1'b1, 1'b1, 16'h8888, 1);
        bus_cycle(16'h1090, 6'h2D, 1'b1, 1'b1, 1'b1, 1'b1, 16'h9999, 1);
        bus_cycle(16'h1000, 6'h2D, 1'b1, 1'b0, 1'b1, 1'b1, 16'h00AA, 1);

        // R9: read in the window
        cur_req = "R9 read acknowledged only";
        bus_cycle(16'h108A, 6'h2D, 1'b0, 1'b1, 1'b1, 1'b1, 16'hBBBB, 2);

        // R10 R6: long hold keeps acknowledge, single strobe
        cur_req = "R10 held strobes";
        bus_cycle(16'h108C, 6'h2D, 1'b1, 1'b1, 1'b1, 1'b1, 16'hC0DE, 12);

        // R6: back-to-back cycles with minimum gap
        cur_req = "R6 back-to-back";
        for (int k = 0; k < 8; k++)
            bus_cycle(16'h1088 + 16'(2 * (k % 4)), 6'h2D, 1'b1, (k % 3) != 1,
                      (k % 3) != 2, 1'b1, 16'(k * 16'h1357), 1 + (k % 2));
        idle(4);

        comparing = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule